// File: doc/BRIEF.md
# Two-Region I2C Register and SRAM Target

This block is an I2C target that answers one fixed 7-bit device address. Behind that address it holds two storage regions in a single byte-wide address map. A 32-byte register block sits at word addresses 0x00 to 0x1F, and a 64-byte scratch SRAM sits at 0x20 to 0x5F. A transaction starts with the control byte. For writes, a one-byte word address follows, then any number of data bytes. Each data byte is stored as soon as it has been received. Reads return bytes from the current pointer until the controller answers with a NACK.

The pointer never crosses from one region into the other. After the last byte of a region it goes back to that region's first byte. An input that signals operation from the backup supply makes the target refuse its own address, so neither region can be reached. SCL and SDA are sampled on a system clock that runs at least eight times the bus rate. SDA is pulled low only through an output-enable that drives an open-drain pad.

Top module: `i2c_regram_target`

## Requirements
- R1: A control byte whose upper seven bits are 1101111 is acknowledged. Bit 0 selects the direction: 0 for write, 1 for read. Any other address is not acknowledged, and the target then acknowledges nothing until the next START.
- R2: While `on_backup` is high, the matching control byte is not acknowledged in either direction. Access works again once `on_backup` is low.
- R3: A word address from 0x00 to 0x5F is acknowledged and loads the pointer. A word address above 0x5F is not acknowledged and leaves the pointer and all storage unchanged.
- R4: Each write data byte is acknowledged, stored at the pointer, and advances the pointer by one inside its region.
- R5: In the register block the pointer advances from 0x1F to 0x00.
- R6: In the SRAM the pointer advances from 0x5F to 0x20.
- R7: A random read works as follows. The controller writes the word address, issues a repeated START with R/W=1, and then reads. The target returns the byte at the pointer, most significant bit first, and advances the pointer after each byte. A controller NACK ends the read and leaves SDA released.
- R8: After reset every register-block byte reads 0x00. SRAM contents are undefined until written.
- R9: There is no page limit. The whole register block or the whole SRAM can be written in a single transaction.
- R10: `sda_oe` is low after reset and after STOP. It changes only while SCL is low.
- R11: A read with no word-address phase (a current-address read) starts at the pointer left by the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| on_backup | input | 1 | High while running from the backup supply; blocks all access |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The assertions assume a well-formed bus:
- Each SCL phase lasts several system clocks.
- SDA moves only while SCL is low, except for START and STOP.
- The controller never issues START or STOP while the target holds SDA low.
- `on_backup` changes only while the bus is idle.

The bench's controller tasks respect all four assumptions. Every SCL phase is at least eight clocks long, and data changes a quarter bit after each falling SCL edge. `on_backup` is toggled only between STOP and the next START. All pad sampling is done on the falling system clock edge.

// File: rtl/i2c_regram_target.sv
module i2c_regram_target #(
  parameter logic [6:0] DEV_ADDR  = 7'b1101111,
  parameter int         REG_BYTES = 32,
  parameter int         RAM_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic on_backup,
  output logic sda_oe
);
  localparam int TOTAL = REG_BYTES + RAM_BYTES;
  localparam int AW    = $clog2(TOTAL);
  localparam int RIW   = $clog2(REG_BYTES);
  localparam int MIW   = $clog2(RAM_BYTES);
  localparam logic [AW-1:0] REG_LAST = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] RAM_BASE = AW'(REG_BYTES);
  localparam logic [AW-1:0] RAM_LAST = AW'(TOTAL - 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WR, S_ACK, S_RD, S_MACK} st_t;

  logic [2:0] scl_sh, sda_sh;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  wire sda_s    = sda_sh[1];
  wire scl_rise = scl_sh[1] & ~scl_sh[2];
  wire scl_fall = ~scl_sh[1] & scl_sh[2];
  wire start_c  = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  wire stop_c   = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];

  st_t           st_q, st_d, nxt_q, nxt_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sr_q, sr_d, tx_q, tx_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          oe_q, oe_d;
  logic          bump, wr_en;

  logic [7:0] regs_q [REG_BYTES];
  logic [7:0] ram_q  [RAM_BYTES];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    if (p == REG_LAST)      return '0;
    else if (p == RAM_LAST) return RAM_BASE;
    else                    return p + AW'(1);
  endfunction

  wire        in_regs = ptr_q < RAM_BASE;
  wire [7:0]  rd_byte = in_regs ? regs_q[ptr_q[RIW-1:0]] : ram_q[MIW'(ptr_q - RAM_BASE)];
  wire        in_ctrl = st_q == S_CTRL;

  always_comb begin
    st_d  = st_q;
    nxt_d = nxt_q;
    bit_d = bit_q;
    sr_d  = sr_q;
    tx_d  = tx_q;
    ptr_d = ptr_q;
    oe_d  = oe_q;
    bump  = 1'b0;
    wr_en = 1'b0;
    if (stop_c) begin
      st_d = S_IDLE;
      oe_d = 1'b0;
    end else if (start_c) begin
      st_d  = S_CTRL;
      bit_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        S_CTRL, S_ADDR, S_WR: begin
          if (scl_rise && bit_q != 4'd8) begin
            sr_d  = {sr_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (st_q == S_CTRL) begin
              if (sr_q[7:1] == DEV_ADDR && !on_backup) begin
                st_d  = S_ACK;
                oe_d  = 1'b1;
                nxt_d = sr_q[0] ? S_RD : S_ADDR;
              end else begin
                st_d = S_IDLE;
              end
            end else if (st_q == S_ADDR) begin
              if (int'(sr_q) < TOTAL) begin
                ptr_d = AW'(sr_q);
                st_d  = S_ACK;
                oe_d  = 1'b1;
                nxt_d = S_WR;
              end else begin
                st_d = S_IDLE;
              end
            end else begin
              wr_en = 1'b1;
              bump  = 1'b1;
              ptr_d = next_ptr(ptr_q);
              st_d  = S_ACK;
              oe_d  = 1'b1;
              nxt_d = S_WR;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            st_d  = nxt_q;
            bit_d = '0;
            if (nxt_q == S_RD) begin
              tx_d = rd_byte;
              oe_d = ~rd_byte[7];
            end else begin
              oe_d = 1'b0;
            end
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d  = 1'b0;
              bump  = 1'b1;
              ptr_d = next_ptr(ptr_q);
              st_d  = S_MACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise && sda_s) begin
            st_d = S_IDLE;
          end else if (scl_fall) begin
            st_d  = S_RD;
            bit_d = '0;
            tx_d  = rd_byte;
            oe_d  = ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      nxt_q <= S_IDLE;
      bit_q <= '0;
      sr_q  <= '0;
      tx_q  <= '0;
      ptr_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
      bit_q <= bit_d;
      sr_q  <= sr_d;
      tx_q  <= tx_d;
      ptr_q <= ptr_d;
      oe_q  <= oe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_BYTES; i++) regs_q[i] <= '0;
    end else if (wr_en && in_regs) begin
      regs_q[ptr_q[RIW-1:0]] <= sr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !in_regs) ram_q[MIW'(ptr_q - RAM_BASE)] <= sr_q;
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_regram_target_chk.sv
module i2c_regram_target_chk #(
  parameter int REG_BYTES = 32,
  parameter int RAM_BYTES = 64,
  parameter int AW        = $clog2(REG_BYTES + RAM_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          on_backup,
  input logic          sda_oe,
  input logic [AW-1:0] ptr,
  input logic          bump,
  input logic          in_ctrl
);
  localparam logic [AW-1:0] REG_LAST = AW'(REG_BYTES - 1);
  localparam logic [AW-1:0] RAM_BASE = AW'(REG_BYTES);
  localparam logic [AW-1:0] RAM_LAST = AW'(REG_BYTES + RAM_BYTES - 1);

  // R3
  ptr_in_map_chk: assert property (@(posedge clk) disable iff (!rst_n) ptr <= RAM_LAST);

  // R4
  region_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && ptr < RAM_BASE) |=> ptr < RAM_BASE);

  // R5
  reg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && ptr == REG_LAST) |=> ptr == '0);

  // R6
  ram_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && ptr == RAM_LAST) |=> ptr == RAM_BASE);

  // R2
  backup_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_backup && $past(on_backup) && $past(in_ctrl)) |-> !sda_oe);

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_regram_target i2c_regram_target_chk #(
  .REG_BYTES(REG_BYTES),
  .RAM_BYTES(RAM_BYTES)
) chk (
  .clk(clk),
  .rst_n(rst_n),
  .scl_i(scl_i),
  .on_backup(on_backup),
  .sda_oe(sda_oe),
  .ptr(ptr_q),
  .bump(bump),
  .in_ctrl(in_ctrl)
);

// File: tb/i2c_regram_target_test.sv
module i2c_regram_target_test;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, on_backup = 1'b0;
  wire  sda_oe;
  wire  sda_line = ~(m_low | sda_oe);

  i2c_regram_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .on_backup(on_backup), .sda_oe(sda_oe)
  );

  always #4 clk = ~clk;

  localparam int Q = 8;
  localparam logic [7:0] CW = 8'hDE, CR = 8'hDF;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] model [96];
  int mp = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int nxt(input int p);
    if (p == 31) return 0;
    if (p == 95) return 32;
    return p + 1;
  endfunction

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); m_low = give_ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); m_low = 1'b0;
  endtask

  task automatic rd_seq(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      item_t e;
      e.v = model[mp]; e.tag = tag;
      exp_q.push_back(e);
      recv(k < n - 1, b);
      got_q.push_back(b);
      mp = nxt(mp);
    end
    bus_stop();
  endtask

  task automatic wr_seq(input int a, input logic [7:0] d[], input string tag);
    bit ack;
    bus_start();
    send(CW, ack);        check({tag, " ctrl ack"}, ack, 1);
    send(8'(a), ack);     check({tag, " addr ack"}, ack, 1);
    mp = a;
    foreach (d[i]) begin
      send(d[i], ack);    check({tag, " R4 data ack"}, ack, 1);
      model[mp] = d[i];
      mp = nxt(mp);
    end
    bus_stop();
  endtask

  task automatic rand_read(input int a, input int n, input string tag);
    bit ack;
    bus_start();
    send(CW, ack);        check({tag, " R1 ctrl ack"}, ack, 1);
    send(8'(a), ack);     check({tag, " addr ack"}, ack, 1);
    mp = a;
    bus_start();
    send(CR, ack);        check({tag, " R7 read ctrl ack"}, ack, 1);
    rd_seq(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bus_start();
    send(CR, ack);        check({tag, " read ctrl ack"}, ack, 1);
    rd_seq(n, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && got_q.size() > 0) begin
        item_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        check(e.tag, g, e.v);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] blk[];
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    check("R10 reset sda_oe", sda_oe, 0);

    wr_seq(8'h1E, '{8'hA1, 8'hA2, 8'hA3}, "R5 reg wrap write");
    rand_read(8'h1E, 3, "R7 R5 reg wrap read");
    rand_read(8'h05, 1, "R8 reset value");
    check("R10 idle after stop", sda_oe, 0);

    wr_seq(8'h5E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6 ram wrap write");
    rand_read(8'h5E, 4, "R6 ram wrap read");

    blk = new[64];
    foreach (blk[i]) blk[i] = 8'(i * 3 + 7);
    wr_seq(8'h20, blk, "R9 full ram write");
    rand_read(8'h20, 65, "R9 R6 full ram read");

    bus_start();
    send(CW, ack);    check("R3 ctrl ack", ack, 1);
    send(8'h60, ack); check("R3 addr 0x60 nack", ack, 0);
    bus_stop();
    bus_start();
    send(CW, ack);    check("R3 ctrl ack", ack, 1);
    send(8'hFF, ack); check("R3 addr 0xFF nack", ack, 0);
    bus_stop();
    cur_read(2, "R3 R11 pointer kept");

    bus_start();
    send(8'hA0, ack); check("R1 foreign address nack", ack, 0);
    send(8'h00, ack); check("R1 silent after mismatch", ack, 0);
    send(8'h55, ack); check("R1 silent after mismatch", ack, 0);
    bus_stop();
    check("R1 sda released", sda_oe, 0);

    on_backup = 1'b1; tick(Q);
    bus_start();
    send(CW, ack);    check("R2 backup write nack", ack, 0);
    bus_stop();
    bus_start();
    send(CR, ack);    check("R2 backup read nack", ack, 0);
    bus_stop();
    on_backup = 1'b0; tick(Q);
    cur_read(1, "R2 R11 access restored");

    blk = new[32];
    foreach (blk[i]) blk[i] = 8'(8'hC5 ^ (i * 5));
    wr_seq(8'h00, blk, "R9 full reg write");
    rand_read(8'h00, 33, "R9 R5 full reg read");
    check("R10 idle at end", sda_oe, 0);

    tick(20);
    check("R7 scoreboard drained", exp_q.size() + got_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule